// File: doc/BRIEF.md
# Cartridge Memory Bank Controller

This block sits between a handheld console's CPU bus and a cartridge's ROM and battery-backed RAM. The CPU cannot address more than 32 KB of ROM and 8 KB of external RAM directly. The controller therefore watches CPU writes that land in the ROM address range. It treats those writes as register updates, not as memory stores. From the resulting register state it maps each CPU address to a physical ROM or RAM address.

Four registers are held: a RAM-enable flag, a 5-bit switchable ROM bank number, a 2-bit upper bank field and a one-bit banking mode. The mode bit sets the job of the upper field.

- In mode 0 the upper field only extends the switchable ROM bank. The RAM bank stays at 0.
- In mode 1 the upper field also selects the RAM bank. It also moves the fixed low ROM window to bank `upper*32`.

The ROM bank presented at the outputs is cut down to a configured number of bank bits, so oversized bank numbers wrap. The address mapping is combinational from the CPU address and the registered state.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset, RAM access is disabled, the switchable ROM bank number is 1, the upper field is 0 and the mode is 0. A read at 0x4000 maps to ROM byte 0x4000, and a read at 0x0000 maps to ROM byte 0.
- R2: A write to 0x0000–0x1FFF sets RAM enable when data bits 3:0 equal 0xA and clears it for any other value. Data bits 7:4 are ignored.
- R3: A write to 0x2000–0x3FFF loads the switchable ROM bank from data bits 4:0. A value of 0 is stored as 1, and data bits 7:5 are ignored.
- R4: A write to 0x4000–0x5FFF loads the upper field from data bits 1:0. Data bits 7:2 are ignored.
- R5: A write to 0x6000–0x7FFF loads the mode from data bit 0. Data bits 7:1 are ignored.
- R6: For addresses 0x4000–0x7FFF, `rom_addr = bank*16384 + addr[13:0]`, where `bank = (upper*32 + low) mod 2^ROM_BANK_BITS`.
- R7: For addresses 0x0000–0x3FFF, the bank is 0 in mode 0. In mode 1 it is `(upper*32) mod 2^ROM_BANK_BITS`, with `rom_addr = bank*16384 + addr[13:0]`.
- R8: For addresses 0xA000–0xBFFF, `ram_sel` is 1 only while RAM is enabled. In that case `ram_addr = rbank*8192 + addr[12:0]`, with `rbank = upper` in mode 1 and 0 in mode 0.
- R9: `rom_sel` equals the inverse of addr bit 15. `ram_sel` is 0 for every address outside 0xA000–0xBFFF.
- R10: Register state changes only on a clock edge where `cpu_we` is high and addr bit 15 is 0. The new mapping appears after that edge, and writes to addresses 0x8000–0xFFFF change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bank registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe, sampled on the rising clock edge |
| rom_addr | output | 14+ROM_BANK_BITS | Physical ROM byte address |
| rom_sel | output | 1 | ROM range selected (addr below 0x8000) |
| ram_addr | output | 13+RAM_BANK_BITS | Physical external RAM byte address |
| ram_sel | output | 1 | External RAM selected and enabled |

## Verification
The hardest state to reach is one where a stored upper field is hidden by mode 0 and must reappear unchanged once mode 1 is selected. This has to hold in both the fixed ROM window and the RAM window, while the bank number also wraps past the configured bank width. The bench sweeps every combination of mode, upper field and 5-bit bank value, writing junk into the ignored data bits each time. After each combination it probes both ROM windows and the RAM window. It uses a narrow ROM bank width so that half of the upper-field values wrap. A separate step drives a write to the upper field and probes the switchable window in the same cycle, before and after the clock edge.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  localparam int LOW_W    = 5;
  localparam int UPPER_W  = 2;
  localparam int FULL_W   = LOW_W + UPPER_W;
  localparam int ROM_OFS_W = 14;
  localparam int RAM_OFS_W = 13;

  typedef enum logic [1:0] {
    SEL_RAM_EN = 2'd0,
    SEL_LOW    = 2'd1,
    SEL_UPPER  = 2'd2,
    SEL_MODE   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic               ram_en;
    logic [LOW_W-1:0]   low;
    logic [UPPER_W-1:0] upper;
    logic               mode;
  } bank_regs_t;

  function automatic reg_sel_e decode_sel(input logic [1:0] a);
    return reg_sel_e'(a);
  endfunction

  function automatic logic ram_en_from(input logic [3:0] nib);
    return nib == 4'hA;
  endfunction

  function automatic logic [LOW_W-1:0] low_from(input logic [LOW_W-1:0] d);
    return (d == '0) ? LOW_W'(1) : d;
  endfunction

  function automatic logic [FULL_W-1:0] switch_bank(input logic [UPPER_W-1:0] up,
                                                    input logic [LOW_W-1:0] lo);
    return {up, lo};
  endfunction

  function automatic logic [FULL_W-1:0] fixed_bank(input logic mode,
                                                   input logic [UPPER_W-1:0] up);
    return mode ? {up, {LOW_W{1'b0}}} : '0;
  endfunction

  function automatic logic [UPPER_W-1:0] ram_bank(input logic mode,
                                                  input logic [UPPER_W-1:0] up);
    return mode ? up : '0;
  endfunction

endpackage

// File: rtl/cbc_regs.sv
module cbc_regs
  import cbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr_hi,
  input  logic [4:0] wdata_lo,
  input  logic       we,
  output bank_regs_t regs_q,
  output logic       wr_ram_en,
  output logic       wr_low,
  output logic       wr_upper,
  output logic       wr_mode
);

  logic     rom_wr;
  reg_sel_e sel;
  logic [3:0] wr_vec;

  assign rom_wr = we & ~addr_hi[2];
  assign sel    = decode_sel(addr_hi[1:0]);

  for (genvar i = 0; i < 4; i++) begin : g_evt
    assign wr_vec[i] = rom_wr && (sel == reg_sel_e'(i));
  end

  assign wr_ram_en = wr_vec[SEL_RAM_EN];
  assign wr_low    = wr_vec[SEL_LOW];
  assign wr_upper  = wr_vec[SEL_UPPER];
  assign wr_mode   = wr_vec[SEL_MODE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q.ram_en <= 1'b0;
      regs_q.low    <= LOW_W'(1);
      regs_q.upper  <= '0;
      regs_q.mode   <= 1'b0;
    end else begin
      if (wr_ram_en) regs_q.ram_en <= ram_en_from(wdata_lo[3:0]);
      if (wr_low)    regs_q.low    <= low_from(wdata_lo);
      if (wr_upper)  regs_q.upper  <= wdata_lo[UPPER_W-1:0];
      if (wr_mode)   regs_q.mode   <= wdata_lo[0];
    end
  end

endmodule

// File: rtl/cbc_rom_map.sv
module cbc_rom_map
  import cbc_pkg::*;
#(
  parameter int ROM_BANK_BITS = 7,
  localparam int ROM_AW = ROM_OFS_W + ROM_BANK_BITS
)(
  input  bank_regs_t        regs,
  input  logic [15:0]       cpu_addr,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_sel
);

  localparam int EXT_W = (ROM_BANK_BITS > FULL_W) ? ROM_BANK_BITS : FULL_W;

  logic [FULL_W-1:0]        bank_full;
  logic [EXT_W-1:0]         bank_ext;
  logic [ROM_BANK_BITS-1:0] bank;

  assign bank_full = cpu_addr[14] ? switch_bank(regs.upper, regs.low)
                                  : fixed_bank(regs.mode, regs.upper);
  assign bank_ext  = EXT_W'(bank_full);
  assign bank      = bank_ext[ROM_BANK_BITS-1:0];

  if (EXT_W > ROM_BANK_BITS) begin : g_wrap
    logic unused_bank_hi;
    assign unused_bank_hi = ^bank_ext[EXT_W-1:ROM_BANK_BITS];
  end

  assign rom_addr = {bank, cpu_addr[ROM_OFS_W-1:0]};
  assign rom_sel  = ~cpu_addr[15];

endmodule

// File: rtl/cbc_ram_map.sv
module cbc_ram_map
  import cbc_pkg::*;
#(
  parameter int RAM_BANK_BITS = 2,
  localparam int RAM_AW = RAM_OFS_W + RAM_BANK_BITS
)(
  input  bank_regs_t        regs,
  input  logic [15:0]       cpu_addr,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_sel
);

  localparam int EXT_W = (RAM_BANK_BITS > UPPER_W) ? RAM_BANK_BITS : UPPER_W;

  logic [EXT_W-1:0]         rbank_ext;
  logic [RAM_BANK_BITS-1:0] rbank;
  logic                     in_window;

  assign rbank_ext = EXT_W'(ram_bank(regs.mode, regs.upper));
  assign rbank     = rbank_ext[RAM_BANK_BITS-1:0];

  if (EXT_W > RAM_BANK_BITS) begin : g_wrap
    logic unused_rbank_hi;
    assign unused_rbank_hi = ^rbank_ext[EXT_W-1:RAM_BANK_BITS];
  end

  assign in_window = (cpu_addr[15:13] == 3'b101);
  assign ram_sel   = in_window & regs.ram_en;
  assign ram_addr  = {rbank, cpu_addr[RAM_OFS_W-1:0]};

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int ROM_BANK_BITS = 7,
  parameter int RAM_BANK_BITS = 2,
  localparam int ROM_AW = ROM_OFS_W + ROM_BANK_BITS,
  localparam int RAM_AW = RAM_OFS_W + RAM_BANK_BITS
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_we,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_sel,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_sel
);

  bank_regs_t regs_q;
  logic       wr_ram_en;
  logic       wr_low;
  logic       wr_upper;
  logic       wr_mode;
  logic       unused_wdata_hi;

  assign unused_wdata_hi = ^cpu_wdata[7:5];

  cbc_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_hi   (cpu_addr[15:13]),
    .wdata_lo  (cpu_wdata[4:0]),
    .we        (cpu_we),
    .regs_q    (regs_q),
    .wr_ram_en (wr_ram_en),
    .wr_low    (wr_low),
    .wr_upper  (wr_upper),
    .wr_mode   (wr_mode)
  );

  cbc_rom_map #(.ROM_BANK_BITS(ROM_BANK_BITS)) u_rom (
    .regs     (regs_q),
    .cpu_addr (cpu_addr),
    .rom_addr (rom_addr),
    .rom_sel  (rom_sel)
  );

  cbc_ram_map #(.RAM_BANK_BITS(RAM_BANK_BITS)) u_ram (
    .regs     (regs_q),
    .cpu_addr (cpu_addr),
    .ram_addr (ram_addr),
    .ram_sel  (ram_sel)
  );

endmodule

// File: rtl/cbc_checker.sv
module cbc_checker
  import cbc_pkg::*;
#(
  parameter int ROM_BANK_BITS = 7,
  parameter int RAM_BANK_BITS = 2
)(
  input logic                     clk,
  input logic                     rst_n,
  input logic [2:0]               addr_hi,
  input logic [4:0]               wdata_lo,
  input logic                     cpu_we,
  input bank_regs_t               regs_q,
  input logic                     wr_ram_en,
  input logic                     wr_low,
  input logic                     wr_upper,
  input logic                     wr_mode,
  input logic [ROM_BANK_BITS-1:0] rom_bank,
  input logic                     rom_sel,
  input logic [RAM_BANK_BITS-1:0] ram_bank_o,
  input logic                     ram_sel
);

  AST_RAMEN_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ram_en |=> regs_q.ram_en == ($past(wdata_lo[3:0]) == 4'hA)); // R2

  AST_LOW_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_low |=> regs_q.low == (($past(wdata_lo) == 5'd0) ? 5'd1 : $past(wdata_lo))); // R3

  AST_UPPER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_upper |=> regs_q.upper == $past(wdata_lo[1:0])); // R4

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> regs_q.mode == $past(wdata_lo[0])); // R5

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_we && !addr_hi[2]) |=> $stable(regs_q)); // R10

  AST_FIXED_WIN_MODE0: assert property (@(posedge clk) disable iff (!rst_n)
    (!regs_q.mode && addr_hi[2:1] == 2'b00) |-> rom_bank == '0); // R7

  AST_RAMSEL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sel |-> regs_q.ram_en); // R8

  AST_RAMBANK_MODE0: assert property (@(posedge clk) disable iff (!rst_n)
    !regs_q.mode |-> ram_bank_o == '0); // R8

  AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_sel && ram_sel)); // R9

endmodule

bind cart_bank_ctrl cbc_checker #(
  .ROM_BANK_BITS(ROM_BANK_BITS),
  .RAM_BANK_BITS(RAM_BANK_BITS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_hi    (cpu_addr[15:13]),
  .wdata_lo   (cpu_wdata[4:0]),
  .cpu_we     (cpu_we),
  .regs_q     (regs_q),
  .wr_ram_en  (wr_ram_en),
  .wr_low     (wr_low),
  .wr_upper   (wr_upper),
  .wr_mode    (wr_mode),
  .rom_bank   (rom_addr[ROM_AW-1:14]),
  .rom_sel    (rom_sel),
  .ram_bank_o (ram_addr[RAM_AW-1:13]),
  .ram_sel    (ram_sel)
);

// File: tb/tb_cart_bank_ctrl.sv
`timescale 1ns/1ps
module tb_cart_bank_ctrl;

  localparam int RBB = 6;
  localparam int RAB = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [15:0]       cpu_addr = '0;
  logic [7:0]        cpu_wdata = '0;
  logic              cpu_we = 1'b0;
  logic [14+RBB-1:0] rom_addr;
  logic              rom_sel;
  logic [13+RAB-1:0] ram_addr;
  logic              ram_sel;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  cart_bank_ctrl #(.ROM_BANK_BITS(RBB), .RAM_BANK_BITS(RAB)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .rom_addr(rom_addr), .rom_sel(rom_sel),
    .ram_addr(ram_addr), .ram_sel(ram_sel)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic probe(input logic [15:0] a);
    cpu_we = 1'b0;
    cpu_addr = a;
    #0.5;
  endtask

  function automatic longint exp_rom(input int bank, input int ofs);
    return longint'((bank % (1 << RBB)) * 16384 + ofs);
  endfunction

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state through the mapping
    probe(16'h4000); chk("R1 switchable window bank1", rom_addr, 64'h4000);
    probe(16'h0123); chk("R1 fixed window bank0", rom_addr, 64'h0123);
    probe(16'hA000); chk("R1 ram disabled", ram_sel, 0);

    // R2: RAM enable decode over every data value
    for (int d = 0; d < 256; d++) begin
      wr(16'(d * 32) & 16'h1FFF, 8'(d));
      probe(16'hA123);
      chk("R2 ram enable decode", ram_sel, ((d & 15) == 10) ? 1 : 0);
    end

    // R9: select decode across the address space (RAM enabled)
    wr(16'h0000, 8'h0A);
    for (int a = 0; a < 65536; a += 512) begin
      probe(16'(a));
      chk("R9 rom_sel", rom_sel, (a < 32768) ? 1 : 0);
      chk("R9 ram_sel", ram_sel, (a >= 16'hA000 && a < 16'hC000) ? 1 : 0);
    end

    // R3 R4 R5 R6 R7 R8: full sweep with junk in ignored data bits
    for (int m = 0; m < 2; m++) begin
      for (int u = 0; u < 4; u++) begin
        for (int l = 0; l < 32; l++) begin
          int eff;
          int ofs;
          int rofs;
          eff  = (l == 0) ? 1 : l;
          ofs  = (l * 517 + u * 33) & 16'h3FFF;
          rofs = (l * 131 + m * 7) & 16'h1FFF;
          wr(16'h6000 + 16'(l << 7), 8'hF0 | 8'(m));
          wr(16'h4000 + 16'(l << 8), 8'hA8 | 8'(u));
          wr(16'h2000 + 16'(l << 8), 8'hE0 | 8'(l));
          probe(16'h4000 + 16'(ofs));
          chk("R6 R3 R4 switchable window", rom_addr, exp_rom(u * 32 + eff, ofs));
          probe(16'(ofs));
          chk("R7 R5 fixed window", rom_addr, (m == 1) ? exp_rom(u * 32, ofs) : ofs);
          probe(16'hA000 + 16'(rofs));
          chk("R8 ram select", ram_sel, 1);
          chk("R8 ram address", ram_addr, longint'(((m == 1) ? u : 0) * 8192 + rofs));
        end
      end
    end

    // R10: upper write takes effect only after the edge
    wr(16'h6000, 8'h01);
    wr(16'h4000, 8'h00);
    wr(16'h2000, 8'h03);
    @(negedge clk);
    cpu_addr = 16'h5000; cpu_wdata = 8'h01; cpu_we = 1'b1;
    #0.5;
    chk("R10 before edge", rom_addr, exp_rom(3, 16'h1000));
    @(negedge clk);
    cpu_we = 1'b0;
    #0.5;
    chk("R10 after edge", rom_addr, exp_rom(35, 16'h1000));

    // R10: writes above 0x7FFF and idle strobes change nothing
    wr(16'hA000, 8'h00);
    wr(16'h8000, 8'h00);
    wr(16'hC000, 8'h00);
    wr(16'hFFFF, 8'h00);
    @(negedge clk);
    cpu_addr = 16'h0000; cpu_wdata = 8'h00; cpu_we = 1'b0;
    @(negedge clk);
    probe(16'h7FFF); chk("R10 switch bank held", rom_addr, exp_rom(35, 16'h3FFF));
    probe(16'h0010); chk("R10 mode held", rom_addr, exp_rom(32, 16'h0010));
    probe(16'hBFFF); chk("R10 ram enable held", ram_sel, 1);
    chk("R10 ram bank held", ram_addr, longint'(1 * 8192 + 16'h1FFF));

    // R8: disabling RAM drops the select
    wr(16'h0000, 8'h00);
    probe(16'hB000); chk("R8 ram disabled", ram_sel, 0);

    // R1: reset again restores defaults
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    probe(16'h4000); chk("R1 after re-reset", rom_addr, 64'h4000);
    probe(16'h0000); chk("R1 fixed after re-reset", rom_addr, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule